// File: doc/BRIEF.md
# Shared-Bus Parity Generator and Checker

This block handles even parity for a parallel shared bus that carries a 32-bit address/data field and a 4-bit command/byte-enable field. Every clock it takes the bus role (initiator or target), the phase type (address phase, write data or read data) and the two ready handshakes. From these it decides whether it should drive parity for the cycle or check parity that the other party drives.

Parity it generates appears on `par_out`, with `par_oe` high, one clock after the bus value it covers. A check compares the expected parity with `par_in` on the following clock. A data-phase mismatch drives the `perr_out` pulse only when `report_en` is set. An address-phase mismatch is only recorded. When the block is the initiator of a write, it watches the error line that the target drives. All detected conditions collect in sticky status bits, and software clears them by writing ones to `status_clr`.

Top module: `bus_parity_unit`

## Requirements
- R1: Generated parity on `par_out` is the XOR of all 36 bits of `{cbe_in, ad_in}`, so that the 37 bits including `par_out` hold an even number of ones.
- R2: As initiator (`is_master`=1), an address phase or a completed write data phase makes `par_oe`=1 on the next clock, with `par_out` covering the bus of that earlier clock.
- R3: As initiator, a completed read data phase is checked. A `par_in` on the next clock that differs from the expected parity is a data parity error.
- R4: As target, an address phase and a completed write data phase are checked on the next clock, and a completed read data phase is generated as in R2.
- R5: A data parity error gives a one-clock `perr_out` pulse on the clock after the compare, and only if `report_en` was 1 at the compare.
- R6: An address parity error sets `status[0]` and never asserts `perr_out`.
- R7: A data parity error sets `status[1]` whatever the value of `report_en`.
- R8: `perr_in`=1 while `is_master`=1 and `wr_phase`=1 sets `status[2]` on the next clock. `perr_in` has no effect in any other role or direction.
- R9: A data phase counts only on a clock where `irdy` and `trdy` are both 1 and `addr_phase` is 0. An incomplete data phase neither generates nor checks.
- R10: Status bits are sticky. A 1 in `status_clr[i]` clears `status[i]`, but a new event on the same clock wins and leaves the bit set.
- R11: While `rst_n` is 0, `par_out`, `par_oe`, `perr_out` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 when this agent is the initiator of the current transaction |
| addr_phase | input | 1 | 1 on the address phase clock |
| wr_phase | input | 1 | 1 when the data phase is a write, 0 for a read |
| irdy | input | 1 | Initiator ready (active high) |
| trdy | input | 1 | Target ready (active high) |
| ad_in | input | 32 | Address/data bus value |
| cbe_in | input | 4 | Command/byte-enable bus value |
| par_in | input | 1 | Parity bit observed on the bus |
| perr_in | input | 1 | Data parity error line driven by the target (active high) |
| report_en | input | 1 | Enables the data parity error output |
| status_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for `par_out` |
| perr_out | output | 1 | Data parity error pulse (active high) |
| status | output | 3 | Sticky flags: [0] address error, [1] data error, [2] target-reported error |

## Verification
The assertions assume that `addr_phase` is never high on the same clock as a completed data transfer, and that role and direction are steady across the clock that follows a phase. The bench keeps to both. It drives one phase and then an idle clock with both ready signals low and `addr_phase` low, and it only switches role while the bus is idle. The one exception is a directed address-then-write-data sequence, which is still legal because the two phases fall on different clocks.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int FOLD_W  = 64;
  localparam int ST_W    = 3;
  localparam int ST_ADDR = 0;
  localparam int ST_DATA = 1;
  localparam int ST_TGT  = 2;

  // Even-parity bit of a zero-padded vector.
  function automatic logic fold_parity(input logic [FOLD_W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < FOLD_W; i++) acc ^= v[i];
    return acc;
  endfunction
endpackage

// File: rtl/bpar_role.sv
module bpar_role (
  input  logic is_master,
  input  logic addr_phase,
  input  logic wr_phase,
  input  logic irdy,
  input  logic trdy,
  output logic gen_fire,
  output logic chk_addr,
  output logic chk_data
);
  logic xfer;
  logic drive_dir;

  assign xfer      = irdy & trdy & ~addr_phase;
  // Initiator drives write data, target drives read data.
  assign drive_dir = (is_master == wr_phase);
  assign gen_fire  = (addr_phase & is_master) | (xfer & drive_dir);
  assign chk_addr  = addr_phase & ~is_master;
  assign chk_data  = xfer & ~drive_dir;
endmodule

// File: rtl/bpar_gen.sv
module bpar_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic par_bit,
  output logic par_out,
  output logic par_oe
);
  logic par_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= fire;
      par_q <= fire ? par_bit : 1'b0;
    end
  end

  assign par_out = par_q;
  assign par_oe  = oe_q;

  assert_gen_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> par_oe);
  assert_gen_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (par_out == $past(par_bit)));
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_addr,
  input  logic chk_data,
  input  logic exp_bit,
  input  logic par_in,
  input  logic report_en,
  output logic perr_out,
  output logic addr_fail,
  output logic data_fail
);
  logic pend_addr_q, pend_data_q, exp_q, perr_q;
  logic miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= 1'b0;
      pend_data_q <= 1'b0;
      exp_q       <= 1'b0;
      perr_q      <= 1'b0;
    end else begin
      pend_addr_q <= chk_addr;
      pend_data_q <= chk_data;
      exp_q       <= exp_bit;
      perr_q      <= data_fail & report_en;
    end
  end

  assign miss      = (par_in != exp_q);
  assign addr_fail = pend_addr_q & miss;
  assign data_fail = pend_data_q & miss;
  assign perr_out  = perr_q;

  assert_addr_no_perr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fail |=> !perr_out);
  assert_perr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_out |-> ($past(report_en) && $past(data_fail)));
  assert_data_fail_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fail && report_en) |=> perr_out);
endmodule

// File: rtl/bpar_status.sv
module bpar_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= (q_r & ~clr) | set;
  end

  assign q = q_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     is_master,
  input  logic                     addr_phase,
  input  logic                     wr_phase,
  input  logic                     irdy,
  input  logic                     trdy,
  input  logic [AD_W-1:0]          ad_in,
  input  logic [BE_W-1:0]          cbe_in,
  input  logic                     par_in,
  input  logic                     perr_in,
  input  logic                     report_en,
  input  logic [bpar_pkg::ST_W-1:0] status_clr,
  output logic                     par_out,
  output logic                     par_oe,
  output logic                     perr_out,
  output logic [bpar_pkg::ST_W-1:0] status
);
  import bpar_pkg::*;

  localparam int BUS_W = AD_W + BE_W;

  logic [FOLD_W-1:0] bus_vec;
  logic              bus_par;
  logic              gen_fire, chk_addr, chk_data;
  logic              addr_fail, data_fail, tgt_err;
  logic [ST_W-1:0]   st_set;

  assign bus_vec = FOLD_W'({cbe_in, ad_in});
  assign bus_par = fold_parity(bus_vec);
  assign tgt_err = perr_in & is_master & wr_phase;

  always_comb begin
    st_set          = '0;
    st_set[ST_ADDR] = addr_fail;
    st_set[ST_DATA] = data_fail;
    st_set[ST_TGT]  = tgt_err;
  end

  bpar_role u_role (
    .is_master (is_master),
    .addr_phase(addr_phase),
    .wr_phase  (wr_phase),
    .irdy      (irdy),
    .trdy      (trdy),
    .gen_fire  (gen_fire),
    .chk_addr  (chk_addr),
    .chk_data  (chk_data)
  );

  bpar_gen u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (gen_fire),
    .par_bit(bus_par),
    .par_out(par_out),
    .par_oe (par_oe)
  );

  bpar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_addr (chk_addr),
    .chk_data (chk_data),
    .exp_bit  (bus_par),
    .par_in   (par_in),
    .report_en(report_en),
    .perr_out (perr_out),
    .addr_fail(addr_fail),
    .data_fail(data_fail)
  );

  bpar_status #(.W(ST_W)) u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (st_set),
    .clr  (status_clr),
    .q    (status)
  );

  initial begin
    if (BUS_W > FOLD_W) $error("bus wider than parity fold");
  end

  assert_incomplete_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase && !(irdy && trdy)) |=> (!par_oe && !addr_fail && !data_fail));
  assert_no_drive_and_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_fire && (chk_addr || chk_data)));
  assert_target_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_in && is_master && wr_phase) |=> status[ST_TGT]);
  assert_target_err_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(perr_in && is_master && wr_phase) && !status[ST_TGT]) |=> !status[ST_TGT]);
endmodule

// File: tb/test_bus_parity_unit.sv
module test_bus_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_master = 1'b0, addr_phase = 1'b0, wr_phase = 1'b0;
  logic        irdy = 1'b0, trdy = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic        par_in = 1'b0, perr_in = 1'b0, report_en = 1'b0;
  logic [2:0]  status_clr = '0;
  logic        par_out, par_oe, perr_out;
  logic [2:0]  status;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  bus_parity_unit i_bus_parity_unit (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .addr_phase(addr_phase),
    .wr_phase(wr_phase), .irdy(irdy), .trdy(trdy), .ad_in(ad_in),
    .cbe_in(cbe_in), .par_in(par_in), .perr_in(perr_in), .report_en(report_en),
    .status_clr(status_clr), .par_out(par_out), .par_oe(par_oe),
    .perr_out(perr_out), .status(status)
  );

  // Vector layout: {ad, cbe, master, addr, wr, bad_par, report_en,
  //                 exp_oe, exp_perr, exp_status[2:0]}
  localparam int NV = 10;
  localparam logic [45:0] VEC [NV] = '{
    {32'h0000_0001, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000},
    {32'hA5A5_0F0F, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000},
    {32'h1234_5678, 4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000},
    {32'hFFFF_FFFF, 4'hE, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010},
    {32'h8000_0000, 4'h1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010},
    {32'hDEAD_BEEF, 4'h6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b001},
    {32'h0F0F_0F0F, 4'hC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000},
    {32'hCAFE_F00D, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010},
    {32'h7777_7777, 4'hB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000},
    {32'h0000_0000, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000}
  };

  // Reference parity: count the ones and take the count modulo two.
  function automatic logic ref_par(input logic [31:0] a, input logic [3:0] c);
    int ones;
    ones = 0;
    for (int i = 0; i < 32; i++) ones += int'(a[i]);
    for (int i = 0; i < 4; i++)  ones += int'(c[i]);
    return (ones % 2) == 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_bus();
    addr_phase = 1'b0; irdy = 1'b0; trdy = 1'b0; perr_in = 1'b0;
  endtask

  task automatic clear_all();
    idle_bus();
    status_clr = 3'b111;
    step();
    status_clr = 3'b000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic p;
    @(negedge clk);
    step();
    check("R11 reset par_oe", 32'(par_oe), 0);
    check("R11 reset par_out", 32'(par_out), 0);
    check("R11 reset perr_out", 32'(perr_out), 0);
    check("R11 reset status", 32'(status), 0);
    rst_n = 1'b1;
    step();

    // Vector walk: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [45:0] e;
      logic [31:0] a;
      logic [3:0]  c;
      e = VEC[v];
      a = e[45:14]; c = e[13:10];
      ad_in = a; cbe_in = c;
      is_master = e[9]; addr_phase = e[8]; wr_phase = e[7];
      irdy = ~e[8]; trdy = ~e[8];
      report_en = e[5];
      step();
      idle_bus();
      ad_in = ~a;
      par_in = ref_par(a, c) ^ e[6];
      check($sformatf("R2 R4 R9 drive enable v%0d", v), 32'(par_oe), 32'(e[4]));
      if (e[4]) check($sformatf("R1 parity value v%0d", v), 32'(par_out), 32'(ref_par(a, c)));
      step();
      check($sformatf("R3 R5 R6 perr_out v%0d", v), 32'(perr_out), 32'(e[3]));
      check($sformatf("R6 R7 status v%0d", v), 32'(status), 32'(e[2:0]));
      clear_all();
    end

    // R1 R2: address then write data back to back as initiator
    is_master = 1'b1; wr_phase = 1'b1;
    addr_phase = 1'b1; ad_in = 32'h0000_0003; cbe_in = 4'h7;
    step();
    check("R2 back-to-back addr oe", 32'(par_oe), 1);
    check("R1 back-to-back addr parity", 32'(par_out), 32'(ref_par(32'h3, 4'h7)));
    addr_phase = 1'b0; irdy = 1'b1; trdy = 1'b1; ad_in = 32'h0100_0000; cbe_in = 4'h0;
    step();
    check("R1 back-to-back data parity", 32'(par_out), 32'(ref_par(32'h0100_0000, 4'h0)));
    idle_bus();
    step();
    check("R2 oe drops when idle", 32'(par_oe), 0);

    // R9: incomplete write (trdy low) generates nothing
    is_master = 1'b1; wr_phase = 1'b1; irdy = 1'b1; trdy = 1'b0; ad_in = 32'h1;
    step();
    idle_bus();
    check("R9 incomplete write no drive", 32'(par_oe), 0);
    // R9: incomplete read with wrong parity afterwards is not checked
    is_master = 1'b1; wr_phase = 1'b0; irdy = 1'b0; trdy = 1'b1; report_en = 1'b1;
    ad_in = 32'h1; cbe_in = 4'h0;
    step();
    idle_bus();
    par_in = 1'b0;
    step();
    check("R9 incomplete read no perr", 32'(perr_out), 0);
    check("R9 incomplete read no status", 32'(status), 0);

    // R8: target-reported error during initiator write
    is_master = 1'b1; wr_phase = 1'b1; perr_in = 1'b1;
    step();
    perr_in = 1'b0;
    check("R8 initiator write records perr_in", 32'(status), 3'b100);
    clear_all();
    is_master = 1'b0; wr_phase = 1'b1; perr_in = 1'b1;
    step();
    perr_in = 1'b0;
    step();
    check("R8 perr_in ignored as target", 32'(status), 0);
    is_master = 1'b1; wr_phase = 1'b0; perr_in = 1'b1;
    step();
    perr_in = 1'b0;
    step();
    check("R8 perr_in ignored on initiator read", 32'(status), 0);

    // R10: set wins over clear on the same clock
    is_master = 1'b1; wr_phase = 1'b1; perr_in = 1'b1;
    step();
    status_clr = 3'b100;
    step();
    check("R10 set wins over clear", 32'(status), 3'b100);
    perr_in = 1'b0;
    step();
    status_clr = 3'b000;
    check("R10 clear when no set", 32'(status), 0);

    // R10: partial clear keeps other bits
    perr_in = 1'b1;
    step();
    perr_in = 1'b0;
    wr_phase = 1'b0; irdy = 1'b1; trdy = 1'b1; report_en = 1'b0;
    ad_in = 32'h0000_00FF; cbe_in = 4'h1;
    p = ref_par(32'h0000_00FF, 4'h1);
    step();
    idle_bus();
    par_in = ~p;
    step();
    check("R7 data error without report", 32'(status), 3'b110);
    check("R5 no perr when disabled", 32'(perr_out), 0);
    status_clr = 3'b010;
    step();
    status_clr = 3'b000;
    check("R10 partial clear", 32'(status), 3'b100);

    // R11: reset in mid-run
    rst_n = 1'b0;
    step();
    check("R11 reset clears status", 32'(status), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule